// File: doc/BRIEF.md
# Dual-Channel Compare-Match Timer

This peripheral holds two independent 16-bit up-counters. Each counter advances once per prescaled tick, and software picks the prescale ratio for each channel. Each counter is compared with its own compare register. When a running counter holds the compare value at a tick, that tick returns the counter to zero. If the channel's interrupt enable is set, the channel also raises a one-cycle pulse on its own interrupt line. The block suits periodic interrupts and interval measurement.

Software reaches the block through a simple 16-bit register bus. The bus carries a byte offset into a 16-byte window, a write strobe, write data and combinational read data. A shared start register turns each channel on or off. Every channel also has a control word, a counter word and a compare word, and all three can be rewritten while the channel runs.

Top module: `cmatch_timer`

## Requirements
- R1: The register map uses byte offsets. Offset 0 is the start register. Channel 0 control, counter and compare are at 2, 4 and 6. Channel 1 control, counter and compare are at 8, 10 and 12.
- R2: In the start register, bit 0 runs channel 0 and bit 1 runs channel 1. Bits [15:2] always read as zero.
- R3: In a control word, bits [1:0] are the prescale select and bit 6 is the interrupt enable. All other bits read as zero and ignore writes, so writing 0xFFFF reads back 0x0043.
- R4: Prescale select values 0, 1, 2 and 3 give one counter increment every 8, 32, 128 and 512 clock cycles. The first increment comes exactly that many cycles after the clock edge that wrote the start bit from 0 to 1.
- R5: At a tick where the counter equals the compare value, the counter becomes 0 instead of incrementing. The period is therefore (compare+1) ticks.
- R6: The clock edge that clears the counter on a match also sets the channel's interrupt output high for exactly one cycle, but only when the interrupt enable bit is 1. With the enable bit 0, the output stays low.
- R7: After reset the start register, both control words and both counters are 0, and both compare registers are 0xFFFF.
- R8: While a channel's start bit is 0, its counter holds its value and its interrupt output stays low.
- R9: Reads of odd offsets and of offsets 14 and 15 return 0xFFFF. Writes to those offsets change no register.
- R10: A software write to a counter wins over a tick in the same cycle. The counter takes the written value, and later ticks count up from it.
- R11: The two channels are independent. Running one channel leaves the other channel's counter and interrupt output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset into the register window |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | 2 | One interrupt pulse line per channel, bit n for channel n |

## Verification
Register writes take effect at the clock edge that samples the write strobe. Reads are combinational, so the bench samples read data a fraction of a cycle after that edge. With a start write at edge 0, the model predicts a counter value of floor(N/D) mod (compare+1) after edge N, where D is the divide ratio. It also predicts an interrupt level of 1 exactly after the edges where N is a nonzero multiple of D·(compare+1). The bench checks both a fixed 2 ns after every edge across the sweeps. For the priority case, the write strobe is placed on edge 16, which is a tick edge at divide-by-8, and the readback is taken after that edge and again one tick later.

// File: rtl/cmatch_pkg.sv
package cmatch_pkg;

    localparam int DATA_W       = 16;
    localparam int ADDR_W       = 4;
    localparam int NUM_CH       = 2;
    localparam int SEL_W        = 2;
    localparam int DIV_BASE_LOG = 3;
    localparam int DIV_STEP_LOG = 2;
    localparam int PRE_W        = DIV_BASE_LOG + DIV_STEP_LOG * ((1 << SEL_W) - 1);
    localparam int IE_BIT       = 6;

    localparam logic [DATA_W-1:0] CMP_RESET = '1;
    localparam logic [DATA_W-1:0] UNMAPPED  = '1;

    typedef enum logic [1:0] {
        RK_CTRL    = 2'd0,
        RK_COUNT   = 2'd1,
        RK_COMPARE = 2'd2,
        RK_NONE    = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic      is_start;
        logic      hit;
        logic      ch;
        reg_kind_e kind;
    } decode_t;

    typedef struct packed {
        logic             irq_en;
        logic [SEL_W-1:0] sel;
    } chan_ctrl_t;

    function automatic logic [PRE_W-1:0] tick_limit(input logic [SEL_W-1:0] sel);
        int shamt;
        shamt = DIV_BASE_LOG + DIV_STEP_LOG * int'(sel);
        return (PRE_W'(1) << shamt) - PRE_W'(1);
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input chan_ctrl_t c);
        logic [DATA_W-1:0] w;
        w            = '0;
        w[SEL_W-1:0] = c.sel;
        w[IE_BIT]    = c.irq_en;
        return w;
    endfunction

    function automatic chan_ctrl_t word_to_ctrl(input logic [DATA_W-1:0] w);
        chan_ctrl_t c;
        c.sel    = w[SEL_W-1:0];
        c.irq_en = w[IE_BIT];
        return c;
    endfunction

endpackage

// File: rtl/cmatch_decode.sv
module cmatch_decode
    import cmatch_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    // Offset within an 8-byte half, in 16-bit words
    logic [1:0] word;
    assign word = addr[2:1];

    always_comb begin
        dec          = '0;
        dec.kind     = RK_NONE;
        dec.ch       = addr[3];
        if (!addr[0]) begin
            if (!addr[3]) begin
                // lower half: word 0 is the start register, channel 0 shifted by one word
                unique case (word)
                    2'd0: dec.is_start = 1'b1;
                    2'd1: begin dec.hit = 1'b1; dec.kind = RK_CTRL;    end
                    2'd2: begin dec.hit = 1'b1; dec.kind = RK_COUNT;   end
                    default: begin dec.hit = 1'b1; dec.kind = RK_COMPARE; end
                endcase
            end else begin
                unique case (word)
                    2'd0: begin dec.hit = 1'b1; dec.kind = RK_CTRL;    end
                    2'd1: begin dec.hit = 1'b1; dec.kind = RK_COUNT;   end
                    2'd2: begin dec.hit = 1'b1; dec.kind = RK_COMPARE; end
                    default: dec.hit = 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/cmatch_prescaler.sv
module cmatch_prescaler
    import cmatch_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PRE_W-1:0] div_q;
    logic [PRE_W-1:0] limit;

    assign limit = tick_limit(sel);
    // >= so a ratio lowered mid-count fires at once instead of wrapping
    assign tick  = run && (div_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + PRE_W'(1);
        end
    end

    // smallest ratio is 8, so two ticks never touch
    assert_tick_gap_R4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/cmatch_channel.sv
module cmatch_channel
    import cmatch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              we_ctrl,
    input  logic              we_count,
    input  logic              we_compare,
    input  logic [DATA_W-1:0] wdata,
    output chan_ctrl_t        ctrl,
    output logic [DATA_W-1:0] count,
    output logic [DATA_W-1:0] compare,
    output logic              irq
);
    chan_ctrl_t        ctrl_q;
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] compare_q;
    logic              irq_q;
    logic              tick;
    logic              match;

    cmatch_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .sel  (ctrl_q.sel),
        .tick (tick)
    );

    assign match = tick && (count_q == compare_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            compare_q <= CMP_RESET;
        end else begin
            if (we_ctrl)    ctrl_q    <= word_to_ctrl(wdata);
            if (we_compare) compare_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (we_count) begin
            count_q <= wdata;
        end else if (match) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= count_q + DATA_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= match && !we_count && ctrl_q.irq_en;
        end
    end

    assign ctrl    = ctrl_q;
    assign count   = count_q;
    assign compare = compare_q;
    assign irq     = irq_q;

    assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && (count_q == compare_q) && !we_count) |=> (count_q == '0));

    assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q);

    assert_irq_enabled_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(ctrl_q.irq_en));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!run && !we_count) |=> $stable(count_q));

    assert_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !run |=> !irq_q);

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
        we_count |=> (count_q == $past(wdata)));
endmodule

// File: rtl/cmatch_timer.sv
module cmatch_timer
    import cmatch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    decode_t           dec;
    logic [NUM_CH-1:0] start_q;
    chan_ctrl_t        ctrl_v    [NUM_CH];
    logic [DATA_W-1:0] count_v   [NUM_CH];
    logic [DATA_W-1:0] compare_v [NUM_CH];

    cmatch_decode u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
        end else if (bus_we && dec.is_start) begin
            start_q <= bus_wdata[NUM_CH-1:0];
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel_me;
        assign sel_me = bus_we && dec.hit && (dec.ch == 1'(c));

        cmatch_channel u_ch (
            .clk        (clk),
            .rst        (rst),
            .run        (start_q[c]),
            .we_ctrl    (sel_me && (dec.kind == RK_CTRL)),
            .we_count   (sel_me && (dec.kind == RK_COUNT)),
            .we_compare (sel_me && (dec.kind == RK_COMPARE)),
            .wdata      (bus_wdata),
            .ctrl       (ctrl_v[c]),
            .count      (count_v[c]),
            .compare    (compare_v[c]),
            .irq        (irq[c])
        );
    end

    always_comb begin
        bus_rdata = UNMAPPED;
        if (dec.is_start) begin
            bus_rdata = {{(DATA_W-NUM_CH){1'b0}}, start_q};
        end else if (dec.hit) begin
            unique case (dec.kind)
                RK_CTRL:    bus_rdata = ctrl_to_word(ctrl_v[dec.ch]);
                RK_COUNT:   bus_rdata = count_v[dec.ch];
                RK_COMPARE: bus_rdata = compare_v[dec.ch];
                default:    bus_rdata = UNMAPPED;
            endcase
        end
    end

    assert_start_upper_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == '0) |-> (bus_rdata[DATA_W-1:NUM_CH] == '0));

    assert_odd_unmapped_R9: assert property (@(posedge clk) disable iff (rst)
        bus_addr[0] |-> (bus_rdata == UNMAPPED));

    assert_start_reset_R7: assert property (@(posedge clk)
        rst |=> (start_q == '0));
endmodule

// File: tb/cmatch_timer_test.sv
`timescale 1ns/1ps
module cmatch_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  bus_addr;
    logic        bus_we;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    cmatch_timer uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [3:0] a_ctrl(input int ch);
        return (ch == 0) ? 4'd2 : 4'd8;
    endfunction
    function automatic logic [3:0] a_cnt(input int ch);
        return (ch == 0) ? 4'd4 : 4'd10;
    endfunction
    function automatic logic [3:0] a_cmp(input int ch);
        return (ch == 0) ? 4'd6 : 4'd12;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        #1;
        bus_we    = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [15:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYCLES);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [15:0] held;
        rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R7: reset values, through the R1 map
        bus_rd(4'd0, v); check("R7 start", v, 16'h0000);
        for (int ch = 0; ch < 2; ch++) begin
            bus_rd(a_ctrl(ch), v); check("R7 ctrl", v, 16'h0000);
            bus_rd(a_cnt(ch), v);  check("R7 count", v, 16'h0000);
            bus_rd(a_cmp(ch), v);  check("R7 compare", v, 16'hFFFF);
        end
        check("R7 irq", {14'b0, irq}, 16'h0000);

        // R1: each mapped offset holds its own value
        bus_wr(4'd4, 16'h1111); bus_wr(4'd6, 16'h2222);
        bus_wr(4'd10, 16'h3333); bus_wr(4'd12, 16'h4444);
        bus_rd(4'd4, v);  check("R1 ch0 count", v, 16'h1111);
        bus_rd(4'd6, v);  check("R1 ch0 compare", v, 16'h2222);
        bus_rd(4'd10, v); check("R1 ch1 count", v, 16'h3333);
        bus_rd(4'd12, v); check("R1 ch1 compare", v, 16'h4444);

        // R3: control masking
        bus_wr(4'd2, 16'hFFFF); bus_rd(4'd2, v); check("R3 ch0 mask", v, 16'h0043);
        bus_wr(4'd8, 16'hFFBC); bus_rd(4'd8, v); check("R3 ch1 mask", v, 16'h0000);
        bus_wr(4'd2, 16'h0000);

        // R9: unmapped reads and ignored writes
        bus_rd(4'd14, v); check("R9 read 14", v, 16'hFFFF);
        bus_rd(4'd15, v); check("R9 read 15", v, 16'hFFFF);
        bus_rd(4'd5, v);  check("R9 read odd", v, 16'hFFFF);
        bus_wr(4'd14, 16'h0000);
        bus_wr(4'd5, 16'h0000);
        bus_wr(4'd13, 16'h0000);
        bus_rd(4'd4, v);  check("R9 ch0 count kept", v, 16'h1111);
        bus_rd(4'd6, v);  check("R9 ch0 compare kept", v, 16'h2222);
        bus_rd(4'd12, v); check("R9 ch1 compare kept", v, 16'h4444);
        bus_rd(4'd0, v);  check("R9 start kept", v, 16'h0000);

        // R2: start register masking
        bus_wr(4'd0, 16'hFFFF); bus_rd(4'd0, v); check("R2 start mask", v, 16'h0003);
        bus_wr(4'd0, 16'h0000); bus_rd(4'd0, v); check("R2 start clear", v, 16'h0000);

        // R4 R5 R6 R11: sweep every channel and ratio, compare = 3
        for (int ch = 0; ch < 2; ch++) begin
            for (int sel = 0; sel < 4; sel++) begin
                int d;
                int per;
                logic [15:0] other_cnt;
                logic [15:0] ie;
                d   = 8 << (2 * sel);
                per = d * 4;
                ie  = (ch == 1 && sel == 0) ? 16'h0000 : 16'h0040;
                bus_wr(4'd0, 16'h0000);
                bus_wr(a_ctrl(ch), ie | 16'(sel));
                bus_wr(a_cnt(ch), 16'h0000);
                bus_wr(a_cmp(ch), 16'h0003);
                bus_rd(a_cnt(1 - ch), other_cnt);
                bus_wr(4'd0, 16'(1 << ch));
                bus_addr = a_cnt(ch);
                for (int n = 1; n <= 2 * per; n++) begin
                    logic [15:0] ec;
                    logic        ei;
                    @(posedge clk); #2;
                    ec = 16'((n / d) % 4);
                    ei = (ie != 0) && (n % per == 0);
                    check("R4/R5 count (R4 R5)", bus_rdata, ec);
                    check("R6 irq", {15'b0, irq[ch]}, {15'b0, ei});
                    check("R11 other irq", {15'b0, irq[1-ch]}, 16'h0000);
                end
                bus_rd(a_cnt(1 - ch), v);
                check("R11 other count", v, other_cnt);
            end
        end

        // R10: write on a tick edge wins, divide by 8, compare max
        bus_wr(4'd0, 16'h0000);
        bus_wr(4'd2, 16'h0000);
        bus_wr(4'd6, 16'hFFFF);
        bus_wr(4'd4, 16'h0000);
        bus_wr(4'd0, 16'h0001);
        repeat (15) @(posedge clk);
        bus_wr(4'd4, 16'h0100);           // strobe sampled on edge 16, a tick edge
        bus_rd(4'd4, v); check("R10 write wins", v, 16'h0100);
        repeat (8) @(posedge clk);
        #1;
        bus_rd(4'd4, v); check("R10 counts on", v, 16'h0101);

        // R8: stopped channel holds and stays quiet
        bus_wr(4'd6, 16'h0000);
        bus_wr(4'd2, 16'h0040);
        bus_wr(4'd0, 16'h0000);
        bus_rd(4'd4, held);
        for (int k = 0; k < 60; k++) begin
            @(posedge clk); #2;
            check("R8 no irq", {14'b0, irq}, 16'h0000);
        end
        bus_rd(4'd4, v); check("R8 count held", v, held);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule